// File: doc/BRIEF.md
# DRAM Idle Low-Power State Controller

This block watches a memory bus for idle time, counted in DFI clock cycles (the DFI clock runs at half the DRAM clock), and steps the memory into deeper low-power modes as that idle time crosses each programmed threshold. Five modes exist, in order of depth:

1. power-down
2. self-refresh
3. self-refresh with controller clock gating
4. self-refresh power-down, offered only for LPDDR4
5. standby, which keeps the memory in self-refresh and gates the controller, PI, PHY and DRAM clocks

Some thresholds count single cycles. Others count units of 1024 cycles.

Every mode change goes through a request/acknowledge handshake with the command sequencer. `enter_req` or `exit_req` is raised together with `req_mode`. The request stays asserted and unchanged until `mode_ack` is sampled high, which is the only back-pressure the block sees. The committed mode, `cur_mode`, changes one cycle after the acknowledge. Any bus activity clears the idle count. If the memory is in a low-power mode, that activity also leads to an exit request back to active.

Top module: `dram_idle_pm`

## Requirements
- R1: Reset state. While reset is applied, and right after it is released, `cur_mode` and `req_mode` are 0 (active), both request outputs are low and all four gate outputs are low.
- R2: Power-down request.
  - Mode codes are: 0 active, 1 power-down, 2 self-refresh, 3 self-refresh with controller gating, 4 self-refresh power-down, 5 standby.
  - After `thr_pd` consecutive idle cycles, `enter_req` rises with `req_mode`=1 on the following cycle, when `thr_pd` is the only threshold set.
- R3: The self-refresh, controller-gating and self-refresh power-down thresholds count units of 1024 idle cycles. The standby threshold counts single cycles.
- R4: A threshold of zero disables its mode. With all thresholds zero, no request is ever raised.
- R5: Self-refresh power-down (code 4) is requested only when `dram_kind` is 2'b10 (LPDDR4). Codes 2'b00 (DDR3) and 2'b01 (LPDDR3) never reach it.
- R6: Mode selection.
  - When several thresholds have been passed, the request names the deepest enabled one.
  - An entry request always names a mode deeper than `cur_mode`.
- R7: A request stays high, with `req_mode` unchanged, until `mode_ack` is sampled high. `cur_mode` takes the requested code on the next cycle.
- R8: Exit on activity.
  - Bus activity while in a low-power mode raises `exit_req` (with `req_mode`=0) on the next cycle and releases all clock gates at once.
  - `exit_req` is held until acknowledged. `cur_mode` is then 0.
- R9: Bus activity seen while an entry request is pending does not abort it. The entry completes, and `exit_req` follows one cycle after the committed mode changes.
- R10: Clock gates.
  - Modes 3 and 4 assert only `gate_ctrl_clk`.
  - Mode 5 asserts all four gate outputs.
  - Modes 0 to 2 assert none.
- R11: The idle counter saturates at its maximum instead of wrapping, so a long wait never makes a passed threshold look unpassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_active | input | 1 | High in any cycle with bus traffic |
| dram_kind | input | 2 | Memory type: 00 DDR3, 01 LPDDR3, 10 LPDDR4 |
| thr_pd | input | PD_W | Power-down threshold, cycles |
| thr_sr | input | SCL_W | Self-refresh threshold, units of 1024 cycles |
| thr_srcg | input | SCL_W | Self-refresh with controller gating threshold, units of 1024 |
| thr_srpd | input | SCL_W | Self-refresh power-down threshold, units of 1024 |
| thr_sb | input | SB_W | Standby threshold, cycles |
| mode_ack | input | 1 | Acknowledge of the pending request |
| enter_req | output | 1 | Request to enter `req_mode` |
| exit_req | output | 1 | Request to return to active |
| req_mode | output | 3 | Mode named by the pending request |
| cur_mode | output | 3 | Committed mode |
| gate_ctrl_clk | output | 1 | Gate the controller clock |
| gate_pi_clk | output | 1 | Gate the PI clock |
| gate_phy_clk | output | 1 | Gate the PHY clock |
| gate_dram_clk | output | 1 | Gate the DRAM clock |

## Verification
**Entry timing.** After N idle cycles the idle count holds N. The entry request is registered one edge later, so a threshold of N gives `enter_req` N+1 clock edges after the bus goes idle. The bench samples both at edge N, where the request must still be low, and at edge N+1.

**Exit timing.** Activity sampled at one edge shows as `exit_req`, with the gates released, right after that same edge.

**Handshake timing.** After an acknowledge, `cur_mode` changes at the acknowledging edge. A deferred exit (R9) appears one edge later.

**Sampling discipline.** Inputs are driven and outputs sampled on the falling edge, and every check counts rising edges from the last change of input.

// File: rtl/dram_pm_pkg.sv
package dram_pm_pkg;

  typedef enum logic [2:0] {
    M_ACTIVE = 3'd0,
    M_PD     = 3'd1,
    M_SR     = 3'd2,
    M_SRCG   = 3'd3,
    M_SRPD   = 3'd4,
    M_SB     = 3'd5
  } pm_mode_e;

  typedef enum logic [1:0] {
    PH_STABLE = 2'd0,
    PH_ENTER  = 2'd1,
    PH_EXIT   = 2'd2
  } pm_phase_e;

  localparam logic [1:0] KIND_LP4 = 2'b10;
  localparam int SCALE_SHIFT = 10;
  localparam int NUM_LP_MODES = 5;

endpackage

// File: rtl/pm_idle_counter.sv
module pm_idle_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else if (count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/pm_mode_select.sv
module pm_mode_select
  import dram_pm_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int PD_W  = 16,
  parameter int SCL_W = 8,
  parameter int SB_W  = 20
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       dram_kind,
  input  logic [PD_W-1:0]  thr_pd,
  input  logic [SCL_W-1:0] thr_sr,
  input  logic [SCL_W-1:0] thr_srcg,
  input  logic [SCL_W-1:0] thr_srpd,
  input  logic [SB_W-1:0]  thr_sb,
  output pm_mode_e         target
);
  logic [CNT_W-1:0]        lim   [NUM_LP_MODES];
  logic [NUM_LP_MODES-1:0] allow;
  logic [NUM_LP_MODES-1:0] passed;
  logic [SCL_W-1:0]        scaled_raw [3];

  assign scaled_raw[0] = thr_sr;
  assign scaled_raw[1] = thr_srcg;
  assign scaled_raw[2] = thr_srpd;

  assign lim[0] = CNT_W'(thr_pd);
  assign lim[4] = CNT_W'(thr_sb);

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_scaled
      assign lim[g+1] = CNT_W'({scaled_raw[g], {SCALE_SHIFT{1'b0}}});
    end
  endgenerate

  assign allow = {1'b1, (dram_kind == KIND_LP4), 3'b111};

  generate
    for (g = 0; g < NUM_LP_MODES; g++) begin : g_pass
      assign passed[g] = allow[g] && (lim[g] != '0) && (count >= lim[g]);
    end
  endgenerate

  always_comb begin
    target = M_ACTIVE;
    for (int i = 0; i < NUM_LP_MODES; i++) begin
      if (passed[i]) target = pm_mode_e'(3'(i + 1));
    end
  end
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import dram_pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_active,
  input  logic      mode_ack,
  input  pm_mode_e  target,
  output pm_phase_e phase,
  output pm_mode_e  cur,
  output pm_mode_e  req
);
  logic wake_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_STABLE;
      cur       <= M_ACTIVE;
      req       <= M_ACTIVE;
      wake_pend <= 1'b0;
    end else begin
      unique case (phase)
        PH_STABLE: begin
          if (cur != M_ACTIVE && (bus_active || wake_pend)) begin
            phase     <= PH_EXIT;
            req       <= M_ACTIVE;
            wake_pend <= 1'b0;
          end else if (!bus_active && target > cur) begin
            phase <= PH_ENTER;
            req   <= target;
          end
        end
        PH_ENTER: begin
          if (bus_active) wake_pend <= 1'b1;
          if (mode_ack) begin
            cur   <= req;
            phase <= PH_STABLE;
          end
        end
        PH_EXIT: begin
          if (mode_ack) begin
            cur   <= M_ACTIVE;
            phase <= PH_STABLE;
          end
        end
        default: phase <= PH_STABLE;
      endcase
    end
  end
endmodule

// File: rtl/pm_gate_map.sv
module pm_gate_map
  import dram_pm_pkg::*;
(
  input  pm_mode_e  cur,
  input  pm_phase_e phase,
  output logic      gate_ctrl,
  output logic      gate_pi,
  output logic      gate_phy,
  output logic      gate_dram
);
  logic hold;
  assign hold      = (phase != PH_EXIT);
  assign gate_ctrl = hold && (cur == M_SRCG || cur == M_SRPD || cur == M_SB);
  assign gate_pi   = hold && (cur == M_SB);
  assign gate_phy  = hold && (cur == M_SB);
  assign gate_dram = hold && (cur == M_SB);
endmodule

// File: rtl/dram_idle_pm.sv
module dram_idle_pm
  import dram_pm_pkg::*;
#(
  parameter int PD_W  = 16,
  parameter int SCL_W = 8,
  parameter int SB_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_active,
  input  logic [1:0]       dram_kind,
  input  logic [PD_W-1:0]  thr_pd,
  input  logic [SCL_W-1:0] thr_sr,
  input  logic [SCL_W-1:0] thr_srcg,
  input  logic [SCL_W-1:0] thr_srpd,
  input  logic [SB_W-1:0]  thr_sb,
  input  logic             mode_ack,
  output logic             enter_req,
  output logic             exit_req,
  output logic [2:0]       req_mode,
  output logic [2:0]       cur_mode,
  output logic             gate_ctrl_clk,
  output logic             gate_pi_clk,
  output logic             gate_phy_clk,
  output logic             gate_dram_clk
);
  localparam int SCL_CYC_W = SCL_W + SCALE_SHIFT;
  localparam int W_A       = (PD_W > SB_W) ? PD_W : SB_W;
  localparam int CNT_W     = (W_A > SCL_CYC_W) ? W_A : SCL_CYC_W;

  logic [CNT_W-1:0] idle_cnt;
  pm_mode_e         target;
  pm_mode_e         cur;
  pm_mode_e         req;
  pm_phase_e        phase;

  pm_idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (bus_active),
    .count (idle_cnt)
  );

  pm_mode_select #(
    .CNT_W (CNT_W),
    .PD_W  (PD_W),
    .SCL_W (SCL_W),
    .SB_W  (SB_W)
  ) u_sel (
    .count     (idle_cnt),
    .dram_kind (dram_kind),
    .thr_pd    (thr_pd),
    .thr_sr    (thr_sr),
    .thr_srcg  (thr_srcg),
    .thr_srpd  (thr_srpd),
    .thr_sb    (thr_sb),
    .target    (target)
  );

  pm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_active (bus_active),
    .mode_ack   (mode_ack),
    .target     (target),
    .phase      (phase),
    .cur        (cur),
    .req        (req)
  );

  pm_gate_map u_gate (
    .cur       (cur),
    .phase     (phase),
    .gate_ctrl (gate_ctrl_clk),
    .gate_pi   (gate_pi_clk),
    .gate_phy  (gate_phy_clk),
    .gate_dram (gate_dram_clk)
  );

  assign enter_req = (phase == PH_ENTER);
  assign exit_req  = (phase == PH_EXIT);
  assign req_mode  = req;
  assign cur_mode  = cur;
endmodule

// File: rtl/dram_idle_pm_chk.sv
module dram_idle_pm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_active,
  input logic [1:0] dram_kind,
  input logic       mode_ack,
  input logic       enter_req,
  input logic       exit_req,
  input logic [2:0] req_mode,
  input logic [2:0] cur_mode,
  input logic       gate_ctrl_clk,
  input logic       gate_pi_clk,
  input logic       gate_phy_clk,
  input logic       gate_dram_clk
);
  a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_req, exit_req}));

  a_r7_enter_held: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req && !mode_ack |=> enter_req && $stable(req_mode));

  a_r7_commit: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req && mode_ack |=> cur_mode == $past(req_mode));

  a_r8_exit_held: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req && !mode_ack |=> exit_req);

  a_r8_exit_done: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req && mode_ack |=> cur_mode == 3'd0);

  a_r8_gates_open: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> !gate_ctrl_clk && !gate_dram_clk);

  a_r6_deeper_only: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |-> req_mode > cur_mode);

  a_r5_lp4_only: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req && req_mode == 3'd4 |-> dram_kind == 2'b10);

  a_r10_dram_gate: assert property (@(posedge clk) disable iff (!rst_n)
    gate_dram_clk |-> cur_mode == 3'd5 && gate_ctrl_clk && gate_pi_clk && gate_phy_clk);

  a_r10_ctrl_gate: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ctrl_clk |-> cur_mode >= 3'd3);
endmodule

bind dram_idle_pm dram_idle_pm_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_active    (bus_active),
  .dram_kind     (dram_kind),
  .mode_ack      (mode_ack),
  .enter_req     (enter_req),
  .exit_req      (exit_req),
  .req_mode      (req_mode),
  .cur_mode      (cur_mode),
  .gate_ctrl_clk (gate_ctrl_clk),
  .gate_pi_clk   (gate_pi_clk),
  .gate_phy_clk  (gate_phy_clk),
  .gate_dram_clk (gate_dram_clk)
);

// File: tb/tb_dram_idle_pm.sv
`timescale 1ns/1ps
module tb_dram_idle_pm;
  localparam int PD_W  = 12;
  localparam int SCL_W = 2;
  localparam int SB_W  = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_active = 1'b0;
  logic [1:0]       dram_kind = 2'b00;
  logic [PD_W-1:0]  thr_pd = '0;
  logic [SCL_W-1:0] thr_sr = '0;
  logic [SCL_W-1:0] thr_srcg = '0;
  logic [SCL_W-1:0] thr_srpd = '0;
  logic [SB_W-1:0]  thr_sb = '0;
  logic             mode_ack = 1'b0;
  logic             enter_req, exit_req;
  logic [2:0]       req_mode, cur_mode;
  logic             gate_ctrl_clk, gate_pi_clk, gate_phy_clk, gate_dram_clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_idle_pm #(.PD_W(PD_W), .SCL_W(SCL_W), .SB_W(SB_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .dram_kind(dram_kind),
    .thr_pd(thr_pd), .thr_sr(thr_sr), .thr_srcg(thr_srcg), .thr_srpd(thr_srpd),
    .thr_sb(thr_sb), .mode_ack(mode_ack), .enter_req(enter_req), .exit_req(exit_req),
    .req_mode(req_mode), .cur_mode(cur_mode), .gate_ctrl_clk(gate_ctrl_clk),
    .gate_pi_clk(gate_pi_clk), .gate_phy_clk(gate_phy_clk), .gate_dram_clk(gate_dram_clk)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int pd, input int sr, input int cg, input int lp,
                          input int sb, input logic [1:0] kind);
    rst_n = 1'b0; bus_active = 1'b0; mode_ack = 1'b0;
    thr_pd = PD_W'(pd); thr_sr = SCL_W'(sr); thr_srcg = SCL_W'(cg);
    thr_srpd = SCL_W'(lp); thr_sb = SB_W'(sb); dram_kind = kind;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic ack_once();
    mode_ack = 1'b1;
    step(1);
    mode_ack = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(5, 0, 0, 0, 0, 2'b00);
    chk("R1 cur_mode", cur_mode, 0);
    chk("R1 req_mode", req_mode, 0);
    chk("R1 requests", {enter_req, exit_req}, 0);
    chk("R1 gates", {gate_ctrl_clk, gate_pi_clk, gate_phy_clk, gate_dram_clk}, 0);
  endtask

  task automatic t_pd_and_exit();
    do_reset(5, 0, 0, 0, 0, 2'b00);
    step(5);
    chk("R2 no early enter", enter_req, 0);
    step(1);
    chk("R2 enter_req", enter_req, 1);
    chk("R2 req_mode pd", req_mode, 1);
    step(3);
    chk("R7 enter held", enter_req, 1);
    chk("R7 cur before ack", cur_mode, 0);
    ack_once();
    chk("R7 cur after ack", cur_mode, 1);
    chk("R7 enter dropped", enter_req, 0);
    bus_active = 1'b1;
    step(1);
    chk("R8 exit_req", exit_req, 1);
    chk("R8 req_mode active", req_mode, 0);
    step(2);
    chk("R8 exit held", exit_req, 1);
    ack_once();
    chk("R8 cur active", cur_mode, 0);
    chk("R8 exit dropped", exit_req, 0);
    bus_active = 1'b0;
  endtask

  task automatic t_zero_disables();
    do_reset(0, 0, 0, 0, 0, 2'b10);
    step(3000);
    chk("R4 all zero no request", {enter_req, exit_req}, 0);
    do_reset(0, 1, 0, 0, 0, 2'b00);
    step(1024);
    chk("R3 no enter before 1024", enter_req, 0);
    step(1);
    chk("R3 enter sr at 1025", enter_req, 1);
    chk("R4 pd skipped, sr named", req_mode, 2);
  endtask

  task automatic t_lp4_gate();
    do_reset(0, 0, 0, 1, 0, 2'b00);
    step(1100);
    chk("R5 ddr3 no srpd", enter_req, 0);
    do_reset(0, 0, 0, 1, 0, 2'b01);
    step(1100);
    chk("R5 lpddr3 no srpd", enter_req, 0);
    do_reset(0, 0, 0, 1, 0, 2'b10);
    step(1025);
    chk("R5 lp4 srpd enter", enter_req, 1);
    chk("R5 lp4 srpd mode", req_mode, 4);
    ack_once();
    chk("R10 srpd ctrl gate", gate_ctrl_clk, 1);
    chk("R10 srpd dram not gated", gate_dram_clk, 0);
  endtask

  task automatic t_deepest();
    do_reset(10, 1, 1, 0, 0, 2'b00);
    step(11);
    chk("R6 first pd", req_mode, 1);
    ack_once();
    chk("R6 cur pd", cur_mode, 1);
    step(1012);
    chk("R6 no enter before 1025", enter_req, 0);
    step(1);
    chk("R6 enter deepest", enter_req, 1);
    chk("R6 deepest srcg", req_mode, 3);
    chk("R10 pd no gates", gate_ctrl_clk, 0);
    ack_once();
    chk("R10 srcg ctrl gate", gate_ctrl_clk, 1);
    chk("R10 srcg pi not gated", {gate_pi_clk, gate_phy_clk, gate_dram_clk}, 0);
  endtask

  task automatic t_standby();
    do_reset(0, 0, 0, 0, 50, 2'b00);
    step(51);
    chk("R3 standby unscaled", enter_req, 1);
    chk("R3 standby mode", req_mode, 5);
    ack_once();
    chk("R10 standby all gates",
        {gate_ctrl_clk, gate_pi_clk, gate_phy_clk, gate_dram_clk}, 15);
    bus_active = 1'b1;
    step(1);
    bus_active = 1'b0;
    chk("R8 exit from standby", exit_req, 1);
    chk("R8 gates released",
        {gate_ctrl_clk, gate_pi_clk, gate_phy_clk, gate_dram_clk}, 0);
    ack_once();
    chk("R8 standby back active", cur_mode, 0);
  endtask

  task automatic t_wake_during_entry();
    do_reset(5, 0, 0, 0, 0, 2'b00);
    step(6);
    chk("R9 entry pending", enter_req, 1);
    bus_active = 1'b1;
    step(1);
    bus_active = 1'b0;
    chk("R9 entry not aborted", enter_req, 1);
    step(2);
    ack_once();
    chk("R9 entry completed", cur_mode, 1);
    chk("R9 no exit yet", exit_req, 0);
    step(1);
    chk("R9 deferred exit", exit_req, 1);
    ack_once();
    chk("R9 back active", cur_mode, 0);
  endtask

  task automatic t_saturate();
    do_reset(4000, 0, 0, 0, 4095, 2'b00);
    step(4001);
    chk("R11 pd enter", req_mode, 1);
    step(3000);
    ack_once();
    chk("R11 cur pd", cur_mode, 1);
    step(1);
    chk("R11 saturated count reaches standby", enter_req, 1);
    chk("R11 standby named", req_mode, 5);
  endtask

  initial begin
    step(2);
    t_reset();
    t_pd_and_exit();
    t_zero_disables();
    t_lp4_gate();
    t_deepest();
    t_standby();
    t_wake_during_entry();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule